// File: doc/BRIEF.md
# NOR Sector Erase Sequencer

This block erases one sector of a parallel NOR flash array built from several identical chips that share one wide data bus, each chip owning its own byte lane. On a start request it latches the sector base address, writes the two-cycle unlock pair, the erase set-up code, a second unlock pair and the sector-erase code. Every command byte is copied into all lanes, so every chip receives the same command in the same cycle.

After the last command write the block reads the status word once per cycle. It decides the outcome for each lane separately. The erase is complete when every chip shows its bit 7 set. A chip that shows its bit 5 set while its bit 7 is still clear has hit an internal timeout. In that case the block writes the reset command and reports a device error. If neither outcome appears within a fixed number of reads, the block gives up and reports a poll timeout. The host sees a busy level, a one-cycle done pulse and a two-bit status code.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, busy, done, the write strobe and the read strobe are all low.
- R2: A start taken while idle yields exactly six write cycles, one per clock, beginning in the cycle after start. Their offsets from the latched sector base are 0x555, 0x2AA, 0x555, 0x555, 0x2AA and 0x555, in that order. Each address is the base plus the offset, modulo 2^ADDR_W.
- R3: The command bytes are 0xAA, 0x55, 0x80, 0xAA, 0x55 and 0x30, in that order, and the reset byte is 0xF0. Each byte sits in bits [7:0] of every lane, and the lane bits above 7 are zero.
- R4: The cycle after the sixth write starts the polling. There is one read per clock at base + 0x555, and a write and a read never fall in the same cycle.
- R5: A read in which bit 7 of every lane is set ends the operation with done and status 0 (complete), and no reset write is made.
- R6: A lane with bit 7 clear and bit 5 set is a device error. The block then makes one write of 0xF0 at base + 0x555 in the next cycle, then pulses done with status 1. Bit 5 of a lane whose bit 7 is set is ignored.
- R7: If a read satisfies R5, that outcome wins over R6. An R5 or R6 outcome on the last allowed read wins over a timeout.
- R8: If POLL_MAX reads pass without an R5 or R6 outcome, done pulses with status 2 right after the last read, and no reset write is made.
- R9: Busy is high from the cycle after an accepted start until done. Done lasts exactly one cycle, and busy is low while it is high.
- R10: A start raised while busy is ignored: the running operation keeps its original sector base. Status holds its value until the next accepted start ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one sector erase |
| sector_base | input | ADDR_W | Word address of the sector start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status | output | 2 | 0 complete, 1 device error, 2 poll timeout |
| flash_addr | output | ADDR_W | Flash word address |
| flash_wdata | output | LANES*LANE_W | Flash write data |
| flash_we | output | 1 | Write strobe, one word per cycle |
| flash_re | output | 1 | Read strobe |
| flash_rdata | input | LANES*LANE_W | Flash read data, valid in the strobe cycle |

## Verification
Two of the block's decisions can fall on the same read. A single status word can carry completion in some lanes and an error flag in others, or completion together with a stale bit 5. An outcome can also arrive on exactly the final read the poll budget allows, where the timeout would otherwise fire. The bench sweeps every per-lane pattern (still busy, finished, failed) against every arrival read from the first to one past the budget. For each case it computes the expected status, the expected read count and whether a reset write must appear, and compares these with what the flash model recorded.

// File: rtl/nes_pkg.sv
package nes_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_DEVERR  = 2'd1,
    ST_TIMEOUT = 2'd2
  } nes_status_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CMD   = 2'd1,
    S_POLL  = 2'd2,
    S_RESET = 2'd3
  } nes_state_e;

  localparam int unsigned CMD_STEPS = 6;
  localparam logic [2:0]  STEP_AUX  = 3'd6;  // reset write and poll address

  // Offset from the sector base for a command step; STEP_AUX selects 0x555.
  function automatic logic [11:0] step_offset(input logic [2:0] s);
    case (s)
      3'd1, 3'd4: step_offset = 12'h2AA;
      default:    step_offset = 12'h555;
    endcase
  endfunction

  // Command byte for a step; STEP_AUX yields the reset code.
  function automatic logic [7:0] step_byte(input logic [2:0] s);
    case (s)
      3'd0, 3'd3: step_byte = 8'hAA;
      3'd1, 3'd4: step_byte = 8'h55;
      3'd2:       step_byte = 8'h80;
      3'd5:       step_byte = 8'h30;
      default:    step_byte = 8'hF0;
    endcase
  endfunction
endpackage

// File: rtl/nes_cmd_table.sv
module nes_cmd_table #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic [2:0]              step,
  input  logic [ADDR_W-1:0]       base,
  output logic [ADDR_W-1:0]       addr,
  output logic [LANES*LANE_W-1:0] data
);
  import nes_pkg::*;

  logic [7:0] cmd_b;
  assign cmd_b = step_byte(step);
  assign addr  = base + ADDR_W'(step_offset(step));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data[l*LANE_W +: LANE_W] = LANE_W'(cmd_b);
  end
endmodule

// File: rtl/nes_lane_eval.sv
module nes_lane_eval #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] word,
  output logic                    all_done,
  output logic                    any_err
);
  logic [LANES-1:0] fin, bad;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign fin[l] = word[l*LANE_W + 7];
    assign bad[l] = ~word[l*LANE_W + 7] & word[l*LANE_W + 5];
  end

  assign all_done = &fin;
  assign any_err  = |bad;
endmodule

// File: rtl/nes_poll_budget.sv
module nes_poll_budget #(
  parameter int POLL_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic last
);
  localparam int CNT_W = $clog2(POLL_MAX + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= CNT_W'(POLL_MAX);
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int POLL_MAX = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       sector_base,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              status,
  output logic [ADDR_W-1:0]       flash_addr,
  output logic [LANES*LANE_W-1:0] flash_wdata,
  output logic                    flash_we,
  output logic                    flash_re,
  input  logic [LANES*LANE_W-1:0] flash_rdata
);
  import nes_pkg::*;

  nes_state_e        state;
  logic [2:0]        step_q;
  logic [ADDR_W-1:0] base_q;
  logic              done_q;
  nes_status_e       status_q;

  // Named internal events
  logic       poll_sample;
  logic       lane_done_all;
  logic       lane_err_any;
  logic       budget_last;
  logic       poll_idle;
  logic [2:0] tbl_step;

  assign poll_sample = (state == S_POLL);
  assign poll_idle   = poll_sample & ~lane_done_all & ~lane_err_any;
  assign tbl_step    = (state == S_CMD) ? step_q : STEP_AUX;

  nes_cmd_table #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_tbl (
    .step (tbl_step),
    .base (base_q),
    .addr (flash_addr),
    .data (flash_wdata)
  );

  nes_lane_eval #(.LANES(LANES), .LANE_W(LANE_W)) u_eval (
    .word     (flash_rdata),
    .all_done (lane_done_all),
    .any_err  (lane_err_any)
  );

  nes_poll_budget #(.POLL_MAX(POLL_MAX)) u_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (state == S_CMD),
    .dec   (poll_idle),
    .last  (budget_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      step_q   <= '0;
      base_q   <= '0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          base_q <= sector_base;
          step_q <= '0;
          state  <= S_CMD;
        end
        S_CMD: begin
          if (step_q == 3'(CMD_STEPS - 1)) state <= S_POLL;
          else step_q <= step_q + 1'b1;
        end
        S_POLL: begin
          if (lane_done_all) begin
            done_q   <= 1'b1;
            status_q <= ST_OK;
            state    <= S_IDLE;
          end else if (lane_err_any) begin
            state <= S_RESET;
          end else if (budget_last) begin
            done_q   <= 1'b1;
            status_q <= ST_TIMEOUT;
            state    <= S_IDLE;
          end
        end
        default: begin
          done_q   <= 1'b1;
          status_q <= ST_DEVERR;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign status   = status_q;
  assign flash_we = (state == S_CMD) || (state == S_RESET);
  assign flash_re = poll_sample;
endmodule

// File: rtl/nes_checker.sv
module nes_checker #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic [1:0]              status,
  input logic [ADDR_W-1:0]       flash_addr,
  input logic [LANES*LANE_W-1:0] flash_wdata,
  input logic                    flash_we,
  input logic                    flash_re,
  input logic                    lane_done_all,
  input logic                    lane_err_any,
  input logic                    budget_last,
  input logic [ADDR_W-1:0]       base_q
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r10_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(base_q));

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_we && flash_re));

  a_r5_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_re && lane_done_all) |=> (done && status == 2'd0 && !flash_we));

  a_r6_reset_write: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_re && !lane_done_all && lane_err_any) |=>
      (flash_we && flash_wdata[7:0] == 8'hF0 &&
       flash_addr == base_q + ADDR_W'(12'h555)));

  a_r8_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_re && !lane_done_all && !lane_err_any && budget_last) |=>
      (done && status == 2'd2 && !flash_we));
endmodule

bind nor_erase_seq nes_checker #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .status        (status),
  .flash_addr    (flash_addr),
  .flash_wdata   (flash_wdata),
  .flash_we      (flash_we),
  .flash_re      (flash_re),
  .lane_done_all (lane_done_all),
  .lane_err_any  (lane_err_any),
  .budget_last   (budget_last),
  .base_q        (base_q)
);

// File: tb/sim_nor_erase_seq.sv
module sim_nor_erase_seq;
  localparam int LANES = 2, LANE_W = 8, ADDR_W = 16, PM = 8;
  localparam int DW = LANES * LANE_W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [ADDR_W-1:0] sector_base = '0;
  logic busy, done, flash_we, flash_re;
  logic [1:0] status;
  logic [ADDR_W-1:0] flash_addr;
  logic [DW-1:0] flash_wdata, flash_rdata;

  always #4 clk = ~clk;  // 125 MHz

  nor_erase_seq #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .POLL_MAX(PM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sector_base(sector_base),
    .busy(busy), .done(done), .status(status), .flash_addr(flash_addr),
    .flash_wdata(flash_wdata), .flash_we(flash_we), .flash_re(flash_re),
    .flash_rdata(flash_rdata)
  );

  // Behavioural flash: logs writes, counts reads, scripted status word.
  logic [ADDR_W-1:0] log_a [0:15];
  logic [DW-1:0]     log_d [0:15];
  int wcnt = 0, rcnt = 0, fin_at = 1;
  logic clr = 1'b0;
  logic [DW-1:0] fin_word = '0;
  localparam logic [DW-1:0] BUSY_WORD = {LANES{8'h44}};

  assign flash_rdata = (rcnt + 1 >= fin_at) ? fin_word : BUSY_WORD;

  always @(posedge clk) begin
    if (clr) begin
      wcnt <= 0; rcnt <= 0;
    end else begin
      if (flash_we) begin
        if (wcnt < 16) begin log_a[wcnt] <= flash_addr; log_d[wcnt] <= flash_wdata; end
        wcnt <= wcnt + 1;
      end
      if (flash_re) rcnt <= rcnt + 1;
    end
  end

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_ofs(input int i);
    case (i) 1, 4: return 12'h2AA; default: return 12'h555; endcase
  endfunction
  function automatic logic [7:0] exp_byte(input int i);
    case (i) 0, 3: return 8'hAA; 1, 4: return 8'h55; 2: return 8'h80;
      5: return 8'h30; default: return 8'hF0; endcase
  endfunction

  task automatic run_case(input logic [ADDR_W-1:0] base, input int fin,
                          input logic [DW-1:0] fw, input bit poke);
    bit alld, anye, outc;
    int exp_reads, exp_st, exp_w, n;
    alld = 1'b1; anye = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      alld &= fw[l*LANE_W+7];
      anye |= ~fw[l*LANE_W+7] & fw[l*LANE_W+5];
    end
    outc = alld | anye;
    if (outc && fin <= PM) begin exp_reads = fin; exp_st = alld ? 0 : 1; end  // R7
    else begin exp_reads = PM; exp_st = 2; end
    exp_w = 6 + ((exp_st == 1) ? 1 : 0);

    @(negedge clk); clr = 1'b1; fin_at = fin; fin_word = fw;
    @(negedge clk); clr = 1'b0; start = 1'b1; sector_base = base;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    if (poke) begin
      start = 1'b1; sector_base = ~base;   // R10: must be ignored
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R9", "done seen", done, 1);
    chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
    chk(int'(status) == exp_st, (exp_st == 0) ? "R5" : (exp_st == 1) ? "R6" : "R8",
        "status", status, exp_st);
    chk(rcnt == exp_reads, "R4", "read count", rcnt, exp_reads);
    chk(wcnt == exp_w, "R6", "write count", wcnt, exp_w);
    for (int i = 0; i < exp_w && i < wcnt; i++) begin
      logic [ADDR_W-1:0] ea;
      ea = base + ADDR_W'(exp_ofs(i));
      chk(log_a[i] == ea, poke ? "R10" : "R2", "write address", log_a[i], ea);
      chk(log_d[i] == {LANES{exp_byte(i)}}, "R3", "write data", log_d[i], {LANES{exp_byte(i)}});
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", done, 0);
    chk(int'(status) == exp_st, "R10", "status holds", status, exp_st);
  endtask

  initial begin
    logic [7:0] pat [0:2];
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && flash_we == 0 && flash_re == 0, "R1", "reset outputs",
        {busy, done, flash_we, flash_re}, 0);
    rst_n = 1'b1;
    for (int fin = 1; fin <= PM + 1; fin++)
      for (int p0 = 0; p0 < 3; p0++)
        for (int p1 = 0; p1 < 3; p1++) begin
          pat[0] = 8'h44;                                 // still busy
          pat[1] = (fin % 2 == 0) ? 8'hA0 : 8'h80;        // finished, stale bit 5 on even
          pat[2] = 8'h60;                                 // failed
          run_case(16'hF000 + ADDR_W'((p0 * 3 + p1) * 16'h0400) + ADDR_W'(fin * 16'h10),
                   fin, {pat[p1], pat[p0]}, fin == 3);
        end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule